// File: doc/BRIEF.md
# Self-Filling Sliding Pixel Window

This block keeps a square window of pixels taken from an image stored row by row in a local line memory, and hands every window pixel to a 2D filter in parallel. After a configuration pulse it fills the column that will enter the window next on its own. It reads one pixel per cycle, but only in cycles when the memory reports that it is idle. Each returned pixel enters the bottom of a column buffer, and the pixels already in the buffer move up one row.

A shift command moves the whole window one column to the left and loads the prepared column into the rightmost column. A shift therefore costs one cycle once the column is ready. If the column is not ready yet, the block raises a stall until the column is complete. The window is 5x5 or 3x3. In 3x3 mode only the bottom-right corner of the register array is presented, and every other tap reads zero. Larger windows must be assembled by the filter's own memory accesses.

Top module: `swin_top`

## Requirements
- R1: During and after reset, `taps` is all zero and `mem_req` and `win_stall` are low.
- R2: `mem_req` is high only in cycles where `mem_idle` is high. The pixel for row r of column c is read from address base + r*stride + c (modulo 2^ADDR_W). Rows are fetched top to bottom, and read data is taken in the cycle after the request.
- R3: After `cfg_load`, reads start with no further command. Exactly one read is made per window row for a column: 5 reads in 5x5 mode, 3 in 3x3 mode. After that no reads are made until the next accepted shift.
- R4: A shift accepted while the prepared column is complete moves every window column one place to the left and puts the prepared column in the rightmost column. `taps` shows the result after that single clock edge.
- R5: While `win_shift` is high and the prepared column is incomplete, `win_stall` is high in the same cycle and the window does not change. The shift takes effect at the first edge where `win_stall` is low.
- R6: The first prepared column is the start column `cfg_col`. Each accepted shift makes the next column (previous + 1) the one to be fetched.
- R7: With `cfg_mode`=0 (3x3), tap i = row*5+col sits at `taps[8*i +: 8]`. Only rows 2..4 and columns 2..4 are live, and they hold image rows 0..2. All other taps are zero.
- R8: With `cfg_mode`=1 (5x5), all 25 taps are live, and tap row r holds image row r. In both modes, tap column 0 holds the oldest column and column 4 the newest.
- R9: `cfg_load` clears the window and restarts fetching for the new settings. A read still in flight from before the load is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_load | input | 1 | Pulse: latch settings, clear window, restart fetching |
| cfg_base | input | ADDR_W | Address of the top-left pixel row |
| cfg_stride | input | ADDR_W | Row pitch in bytes |
| cfg_mode | input | 1 | 0 = 3x3 window, 1 = 5x5 window |
| cfg_col | input | ADDR_W | First column to be fetched |
| win_shift | input | 1 | Shift request, held until `win_stall` is low |
| win_stall | output | 1 | Shift requested but next column not ready |
| mem_idle | input | 1 | Memory free for a background read this cycle |
| mem_req | output | 1 | Background read request |
| mem_addr | output | ADDR_W | Read address |
| mem_rdata | input | 8 | Read data, one cycle after the request |
| taps | output | 200 | All 25 window pixels, tap i at bits [8*i+7:8*i] |

## Verification
Two things can fall in the same cycle: a shift request, and the background fetch still finishing the next column. The fetch may finish in the very edge where its last pixel returns. Memory idle time is throttled with rotating idle patterns, and in one directed case it is held at zero, so that shift requests arrive while the column is incomplete. In that case the bench requires the stall to be high and the window to be frozen, and then requires the shift to complete once idle cycles resume. Every outcome is judged by comparing the full tap bus with pixel values computed from a known memory image.

// File: rtl/swin_pkg.sv
// Shared definitions for the sliding pixel window.
// Assumes pixels are one byte and the largest window is 5x5.
package swin_pkg;
    typedef enum logic {WIN_SMALL = 1'b0, WIN_LARGE = 1'b1} win_mode_e;
    localparam int PIX_W = 8;
endpackage

// File: rtl/swin_fetch.sv
// Background column fetcher: reads the next window column from memory in idle
// cycles, pushing each pixel into the bottom of a column buffer (upward shift).
// Assumes one-cycle memory read latency and that `take` is only asserted when
// col_ready is high.
module swin_fetch
    import swin_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int SPAN   = 5,
    parameter int SMALL  = 3
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            cfg_load,
    input  logic [ADDR_W-1:0]               cfg_base,
    input  logic [ADDR_W-1:0]               cfg_stride,
    input  logic                            cfg_mode,
    input  logic [ADDR_W-1:0]               cfg_col,
    input  logic                            take,
    input  logic                            mem_idle,
    input  logic [PIX_W-1:0]                mem_rdata,
    output logic                            mem_req,
    output logic [ADDR_W-1:0]               mem_addr,
    output logic [SPAN-1:0][PIX_W-1:0]      col_data,
    output logic                            col_ready,
    output logic                            mode_large
);
    localparam int CNT_W = $clog2(SPAN + 1);

    logic                       active;
    win_mode_e                  mode_q;
    logic [ADDR_W-1:0]          base_q, stride_q, col_q, row_off;
    logic [CNT_W-1:0]           iss_cnt, rcv_cnt, rows_needed;
    logic                       rd_pend;
    logic [SPAN-1:0][PIX_W-1:0] colbuf;

    // Number of rows a column needs in the current mode.
    always_comb rows_needed = (mode_q == WIN_LARGE) ? CNT_W'(SPAN) : CNT_W'(SMALL);

    // Request a read while the column is short of rows and memory is free.
    always_comb begin
        mem_req   = active && mem_idle && (iss_cnt < rows_needed);
        mem_addr  = base_q + col_q + row_off;
        col_ready = active && (rcv_cnt == rows_needed);
        col_data  = colbuf;
        mode_large = (mode_q == WIN_LARGE);
    end

    // Settings, counters and upward-shifting column buffer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active   <= 1'b0;
            mode_q   <= WIN_SMALL;
            base_q   <= '0;
            stride_q <= '0;
            col_q    <= '0;
            row_off  <= '0;
            iss_cnt  <= '0;
            rcv_cnt  <= '0;
            rd_pend  <= 1'b0;
            colbuf   <= '0;
        end else if (cfg_load) begin
            active   <= 1'b1;
            mode_q   <= win_mode_e'(cfg_mode);
            base_q   <= cfg_base;
            stride_q <= cfg_stride;
            col_q    <= cfg_col;
            row_off  <= '0;
            iss_cnt  <= '0;
            rcv_cnt  <= '0;
            rd_pend  <= 1'b0;
            colbuf   <= '0;
        end else if (take) begin
            col_q   <= col_q + 1'b1;
            row_off <= '0;
            iss_cnt <= '0;
            rcv_cnt <= '0;
            rd_pend <= 1'b0;
        end else begin
            if (mem_req) begin
                iss_cnt <= iss_cnt + 1'b1;
                row_off <= row_off + stride_q;
            end
            rd_pend <= mem_req;
            if (rd_pend) begin
                for (int k = 0; k < SPAN - 1; k++) colbuf[k] <= colbuf[k+1];
                colbuf[SPAN-1] <= mem_rdata;
                rcv_cnt <= rcv_cnt + 1'b1;
            end
        end
    end

    // R2: consecutive reads of one column step down by exactly one row pitch.
    p_addr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && $past(mem_req) && !$past(cfg_load) && !$past(take)
        |-> mem_addr == $past(mem_addr) + stride_q);

    // R3: a complete column issues no further reads.
    p_ready_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        col_ready |-> !mem_req);

    // R3: never more data received than requested.
    p_rcv_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rcv_cnt <= iss_cnt);

    // R5: a ready column stays ready until taken or reconfigured.
    p_ready_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        col_ready && !take && !cfg_load |=> col_ready);
endmodule

// File: rtl/swin_array.sv
// Window register array: shifts left one column on command and loads the
// prepared column on the right. Outputs a flat tap bus, zeroing taps that
// lie outside the bottom-right corner in small mode.
// Assumes col_data row k is window row k (top = 0).
module swin_array
    import swin_pkg::*;
#(
    parameter int SPAN  = 5,
    parameter int SMALL = 3
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              clear,
    input  logic                              shift,
    input  logic                              mode_large,
    input  logic [SPAN-1:0][PIX_W-1:0]        col_data,
    output logic [SPAN*SPAN*PIX_W-1:0]        taps
);
    logic [SPAN-1:0][SPAN-1:0][PIX_W-1:0] win;

    // Clear on reset or reload, otherwise shift left on command.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            win <= '0;
        end else if (shift) begin
            for (int r = 0; r < SPAN; r++) begin
                for (int c = 0; c < SPAN - 1; c++) win[r][c] <= win[r][c+1];
                win[r][SPAN-1] <= col_data[r];
            end
        end
    end

    // Tap presentation with corner masking in small mode.
    for (genvar r = 0; r < SPAN; r++) begin : g_row
        for (genvar c = 0; c < SPAN; c++) begin : g_col
            localparam bit IN_CORNER = (r >= SPAN - SMALL) && (c >= SPAN - SMALL);
            if (IN_CORNER) begin : g_live
                assign taps[(r*SPAN+c)*PIX_W +: PIX_W] = win[r][c];
            end else begin : g_masked
                assign taps[(r*SPAN+c)*PIX_W +: PIX_W] = mode_large ? win[r][c] : '0;
            end
        end
    end

    // R5: without a shift or clear the window holds.
    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !shift && !clear |=> $stable(win));

    // R4: a shift loads the new column on the right and moves the rest left.
    p_shift_left_r4: assert property (@(posedge clk) disable iff (!rst_n)
        shift && !clear |=> (win[SPAN-1][SPAN-1] == $past(col_data[SPAN-1]))
                          && (win[0][0] == $past(win[0][1])));

    // R9: a clear empties the window.
    p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> win == '0);
endmodule

// File: rtl/swin_top.sv
// Self-filling sliding pixel window: joins the background fetcher and the
// window array, accepting a shift only when the next column is complete.
// Assumes the memory returns read data one cycle after mem_req.
module swin_top
    import swin_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int SPAN   = 5,
    parameter int SMALL  = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cfg_load,
    input  logic [ADDR_W-1:0]           cfg_base,
    input  logic [ADDR_W-1:0]           cfg_stride,
    input  logic                        cfg_mode,
    input  logic [ADDR_W-1:0]           cfg_col,
    input  logic                        win_shift,
    output logic                        win_stall,
    input  logic                        mem_idle,
    output logic                        mem_req,
    output logic [ADDR_W-1:0]           mem_addr,
    input  logic [PIX_W-1:0]            mem_rdata,
    output logic [SPAN*SPAN*PIX_W-1:0]  taps
);
    logic                       col_ready, take, mode_large;
    logic [SPAN-1:0][PIX_W-1:0] col_data;

    // Accept a shift when the column is ready; stall otherwise.
    always_comb begin
        take      = win_shift && col_ready && !cfg_load;
        win_stall = win_shift && !col_ready;
    end

    swin_fetch #(.ADDR_W(ADDR_W), .SPAN(SPAN), .SMALL(SMALL)) u_fetch (
        .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_base(cfg_base),
        .cfg_stride(cfg_stride), .cfg_mode(cfg_mode), .cfg_col(cfg_col),
        .take(take), .mem_idle(mem_idle), .mem_rdata(mem_rdata),
        .mem_req(mem_req), .mem_addr(mem_addr), .col_data(col_data),
        .col_ready(col_ready), .mode_large(mode_large)
    );

    swin_array #(.SPAN(SPAN), .SMALL(SMALL)) u_array (
        .clk(clk), .rst_n(rst_n), .clear(cfg_load), .shift(take),
        .mode_large(mode_large), .col_data(col_data), .taps(taps)
    );

    // R2: background reads only in memory-idle cycles.
    p_req_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> mem_idle);

    // R1: outputs quiet in the first cycle after reset.
    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> !mem_req && taps == '0);
endmodule

// File: tb/tb_swin_top.sv
module tb_swin_top;
    localparam int AW = 12;
    localparam int TW = 200;

    typedef struct packed {
        logic          m;
        logic [AW-1:0] base;
        logic [AW-1:0] stride;
        logic [AW-1:0] col;
        logic [7:0]    idle;
        logic [3:0]    ns;
    } vec_t;

    localparam vec_t VEC [6] = '{
        '{1'b1, 12'h100, 12'd40, 12'd3,  8'hFF, 4'd5},
        '{1'b1, 12'h040, 12'd64, 12'd0,  8'hA5, 4'd7},
        '{1'b0, 12'h200, 12'd20, 12'd10, 8'hFF, 4'd3},
        '{1'b0, 12'h7F0, 12'd32, 12'd5,  8'h11, 4'd4},
        '{1'b1, 12'hFF0, 12'd16, 12'd2,  8'h3C, 4'd2},
        '{1'b0, 12'h010, 12'd8,  12'd0,  8'h80, 4'd6}
    };

    logic clk = 0, rst_n = 0;
    logic cfg_load = 0, cfg_mode = 0, win_shift = 0, win_stall;
    logic [AW-1:0] cfg_base = 0, cfg_stride = 0, cfg_col = 0;
    logic mem_idle = 0, mem_req;
    logic [AW-1:0] mem_addr;
    logic [7:0] mem_rdata = 0;
    logic [TW-1:0] taps;
    logic [7:0] idle_pat = 8'hFF;
    logic [2:0] phase = 0;
    int total = 0, bad = 0, viol = 0, reqs = 0;

    always #5 clk = ~clk;

    swin_top dut (
        .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_base(cfg_base),
        .cfg_stride(cfg_stride), .cfg_mode(cfg_mode), .cfg_col(cfg_col),
        .win_shift(win_shift), .win_stall(win_stall), .mem_idle(mem_idle),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rdata(mem_rdata), .taps(taps)
    );

    function automatic logic [7:0] pix(input int a);
        int v;
        v = (a % 4096) * 37 + 11;
        return v[7:0];
    endfunction

    // Expected tap bus after n shifts from start column c0 (R4 R6 R7 R8).
    function automatic logic [TW-1:0] exp_taps(input logic m, input int base,
                                              input int stride, input int c0, input int n);
        logic [TW-1:0] t;
        t = '0;
        for (int i = 0; i < 25; i++) begin
            int r, c, mrow, icol;
            r = i / 5; c = i % 5;
            if ((m || (r >= 2 && c >= 2)) && (n >= 5 - c)) begin
                mrow = m ? r : r - 2;
                icol = c0 + n - 5 + c;
                t[8*i +: 8] = pix(base + mrow * stride + icol);
            end
        end
        return t;
    endfunction

    // Memory model with one-cycle read latency.
    always @(posedge clk) mem_rdata <= pix(int'(mem_addr));

    // Idle-cycle generator from a rotating pattern.
    always @(negedge clk) begin
        mem_idle <= idle_pat[phase];
        phase <= phase + 1'b1;
    end

    // Read monitor: counts requests and requests outside idle cycles.
    always @(posedge clk) if (rst_n && mem_req) begin
        reqs <= reqs + 1;
        if (!mem_idle) viol <= viol + 1;
    end

    task automatic check(input string req, input logic [TW-1:0] act, input logic [TW-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic load(input logic m, input int base, input int stride, input int col);
        @(negedge clk);
        cfg_mode = m; cfg_base = AW'(base); cfg_stride = AW'(stride); cfg_col = AW'(col);
        cfg_load = 1;
        @(negedge clk);
        cfg_load = 0;
    endtask

    task automatic do_shift();
        @(negedge clk);
        win_shift = 1;
        #1;
        while (win_stall) begin @(negedge clk); #1; end
        @(negedge clk);
        win_shift = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 taps", taps, '0);
        check("R1 req/stall", TW'({mem_req, win_stall}), '0);
        rst_n = 1;
        @(negedge clk);

        // Table of vectors (R2 R4 R6 R7 R8)
        foreach (VEC[v]) begin
            idle_pat = VEC[v].idle;
            load(VEC[v].m, VEC[v].base, VEC[v].stride, VEC[v].col);
            for (int s = 0; s < int'(VEC[v].ns); s++) do_shift();
            if (VEC[v].m)
                check("R8 R4 R6 window 5x5", taps, exp_taps(1'b1, VEC[v].base, VEC[v].stride, VEC[v].col, VEC[v].ns));
            else
                check("R7 R4 R6 window 3x3", taps, exp_taps(1'b0, VEC[v].base, VEC[v].stride, VEC[v].col, VEC[v].ns));
        end

        // R3: read count per column, 5x5 and 3x3
        idle_pat = 8'hFF;
        load(1'b1, 12'h300, 24, 1);
        reqs = 0;
        repeat (20) @(negedge clk);
        check("R3 reads 5x5", TW'(reqs), TW'(5));
        load(1'b0, 12'h300, 24, 1);
        reqs = 0;
        repeat (20) @(negedge clk);
        check("R3 reads 3x3", TW'(reqs), TW'(3));

        // R5: shift with incomplete column stalls and freezes window
        idle_pat = 8'h00;
        load(1'b1, 12'h020, 30, 4);
        check("R9 cleared", taps, '0);
        @(negedge clk);
        win_shift = 1;
        #1;
        check("R5 stall high", TW'(win_stall), TW'(1));
        repeat (4) @(negedge clk);
        check("R5 window frozen", taps, '0);
        idle_pat = 8'hFF;
        #1;
        while (win_stall) begin @(negedge clk); #1; end
        @(negedge clk);
        win_shift = 0;
        check("R5 shift after stall", taps, exp_taps(1'b1, 12'h020, 30, 4, 1));

        // R9: reload during fetch discards in-flight read
        idle_pat = 8'hFF;
        load(1'b1, 12'h500, 50, 7);
        @(negedge clk);
        load(1'b1, 12'h0A0, 12, 9);
        for (int s = 0; s < 5; s++) do_shift();
        check("R9 reload", taps, exp_taps(1'b1, 12'h0A0, 12, 9, 5));

        // R2: no read outside idle cycles during the whole run
        check("R2 idle-only reads", TW'(viol), '0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule